// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the read and write strobes of a parallel ATA channel pair. It holds a 16-bit timing word for each of four units. A unit is one device on one channel, and its index is 2 × channel + device. Each byte of a timing word stores the number of active clocks and the number of recovery clocks in offset form. The low nibble holds 17 minus the active count. The high nibble holds 16 minus the recovery count. The low byte times reads and the high byte times writes. A control byte holds one bit per unit that decides whether the device's ready line may stretch the active phase. A status byte mirrors the host's posted-write-buffer busy flags. While any of those flags is set, configuration writes are refused.

A transfer starts with a one-clock `req` that gives the unit and the direction. The block copies that unit's timing and ready setting at that moment. It holds the matching strobe for the active count, then keeps the bus idle for the recovery count. It then pulses `done` and is ready for the next request in that same clock. With one count per 30 ns clock, the active time spans 60 to 510 ns and the recovery time spans 30 to 480 ns.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset the block is idle with both strobes, `busy` and `done` low. Every timing word reads 0x0000 (17 active and 16 recovery clocks). The control byte reads 0xF0, so the ready line is ignored for every unit.
- R2: Byte-wide writes decode as follows:
  - Unit u's timing word sits at 0x44 + 2u, low byte at the even address.
  - The control byte sits at 0x42. Only bits 7:4 are kept, and bit 4 + u belongs to unit u. Bits 3:0 read as 0.
  - 0x43 reads {6'b0, wbuf_busy}.
  - Any other address reads 0.
- R3: The strobe stays high for exactly 17 − N clocks, where N is the low nibble of the selected byte (0..15, giving 2..17 clocks). A read request uses the low byte and a write request uses the high byte.
- R4: After the strobe falls, `busy` stays high with both strobes low for exactly 16 − M clocks, where M is the high nibble of the selected byte (1..16 clocks). `done` is then high for exactly one clock with `busy` low.
- R5: A read request (`req_write`=0) raises only `rd_strobe`. A write request raises only `wr_strobe`. The two strobes are never high together.
- R6: When the unit's control bit is 0 and `iordy` is low, the strobe stays high past its programmed count. It falls one clock after `iordy` is sampled high. When the unit's control bit is 1, `iordy` has no effect on strobe length.
- R7: While `wbuf_busy` is nonzero, writes to the control byte and to the timing words are discarded. The stored values and the strobe timing of later cycles are unchanged.
- R8: Timing and ready settings are copied when `req` is accepted. A change written during a cycle has no effect on that cycle and applies from the next request onward.
- R9: A `req` that arrives while `busy` is high is ignored. No extra cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational readback of `cfg_addr` |
| wbuf_busy | input | 2 | Posted-write-buffer busy flags |
| req | input | 1 | Start-of-cycle pulse |
| req_unit | input | UNIT_W | Unit index, 2 × channel + device |
| req_write | input | 1 | 1 selects a write cycle, 0 a read cycle |
| iordy | input | 1 | Device ready line, synchronous to `clk` |
| rd_strobe | output | 1 | Active-high read strobe |
| wr_strobe | output | 1 | Active-high write strobe |
| busy | output | 1 | A cycle is in its active or recovery phase |
| done | output | 1 | One-clock pulse at the end of recovery |

## Verification
The bench builds the block with its default parameters: four units, 8-bit addresses, timing words based at 0x44 and the control byte at 0x42. With these values every unit and both byte lanes can be reached. Nibble codes at both ends of the range exercise the 2- and 17-clock active limits and the 1- and 16-clock recovery limits. The 5-bit counter therefore runs to its largest legal load. Ready-line stretching is driven past, at and below the programmed count. Writes and requests are injected mid-cycle to exercise the copy-at-request rule.

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int UNITS = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W = 5,
  parameter int IRDY_LSB = 4,
  parameter logic [ADDR_W-1:0] TIM_BASE = 8'h44,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h42,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h43,
  localparam int UNIT_W = $clog2(UNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [1:0]        wbuf_busy,
  input  logic              req,
  input  logic [UNIT_W-1:0] req_unit,
  input  logic              req_write,
  input  logic              iordy,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] TIM_SPAN = ADDR_W'(2 * UNITS);
  localparam logic [CNT_W-1:0] ACT_OFS = CNT_W'(17);
  localparam logic [CNT_W-1:0] REC_OFS = CNT_W'(16);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_REC} st_t;

  logic [15:0]       tim [UNITS];
  logic [UNITS-1:0]  ign_rdy;
  logic [16*UNITS-1:0] tim_flat;

  logic [ADDR_W-1:0] tim_off;
  logic              tim_hit, ctrl_hit, wr_ok;

  st_t               st;
  logic [CNT_W-1:0]  cnt, rec_hold;
  logic [UNIT_W-1:0] cur_unit;
  logic              cur_wr, cur_ign;

  logic [7:0]        sel_byte;
  logic [CNT_W-1:0]  act_ld, rec_ld;

  assign wr_ok    = cfg_wr && (wbuf_busy == 2'b00);
  assign tim_off  = cfg_addr - TIM_BASE;
  assign tim_hit  = (cfg_addr >= TIM_BASE) && (tim_off < TIM_SPAN);
  assign ctrl_hit = (cfg_addr == CTRL_ADDR);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tim[u]     <= '0;
        ign_rdy[u] <= 1'b1;
      end else begin
        if (wr_ok && tim_hit && tim_off[UNIT_W:1] == UNIT_W'(u)) begin
          if (tim_off[0]) tim[u][15:8] <= cfg_wdata;
          else            tim[u][7:0]  <= cfg_wdata;
        end
        if (wr_ok && ctrl_hit)
          ign_rdy[u] <= cfg_wdata[IRDY_LSB + u];
      end
    end
    assign tim_flat[16*u +: 16] = tim[u];
  end

  always_comb begin
    cfg_rdata = '0;
    if (tim_hit)
      cfg_rdata = tim_off[0] ? tim[tim_off[UNIT_W:1]][15:8] : tim[tim_off[UNIT_W:1]][7:0];
    else if (ctrl_hit)
      cfg_rdata[IRDY_LSB +: UNITS] = ign_rdy;
    else if (cfg_addr == STAT_ADDR)
      cfg_rdata[1:0] = wbuf_busy;
  end

  assign sel_byte = req_write ? tim[req_unit][15:8] : tim[req_unit][7:0];
  assign act_ld   = ACT_OFS - {{(CNT_W-4){1'b0}}, sel_byte[3:0]};
  assign rec_ld   = REC_OFS - {{(CNT_W-4){1'b0}}, sel_byte[7:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rec_hold <= '0;
      cur_unit <= '0;
      cur_wr   <= 1'b0;
      cur_ign  <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st       <= S_ACT;
          cnt      <= act_ld;
          rec_hold <= rec_ld;
          cur_unit <= req_unit;
          cur_wr   <= req_write;
          cur_ign  <= ign_rdy[req_unit];
        end
        S_ACT: begin
          if (cnt > 1)
            cnt <= cnt - 1'b1;
          else if (cur_ign || iordy) begin
            st  <= S_REC;
            cnt <= rec_hold;
          end
        end
        S_REC: begin
          if (cnt > 1)
            cnt <= cnt - 1'b1;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign rd_strobe = (st == S_ACT) && !cur_wr;
  assign wr_strobe = (st == S_ACT) &&  cur_wr;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe)); // R5
  AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT) |-> (cnt >= 1 && cnt <= 17)); // R3
  AST_DONE_FROM_REC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st == S_REC) && !busy)); // R4
  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && cnt == 1 && !cur_ign && !iordy) |=> (st == S_ACT)); // R6
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wbuf_busy != 2'b00) |=> ($stable(tim_flat) && $stable(ign_rdy))); // R7
  AST_BUSY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(cur_unit) && $stable(cur_wr))); // R9

endmodule

// File: tb/test_pio_strobe_gen.sv
`timescale 1ns/1ps
module test_pio_strobe_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [1:0] wbuf_busy = '0;
  logic req = 1'b0, req_write = 1'b0, iordy = 1'b1;
  logic [1:0] req_unit = '0;
  logic rd_strobe, wr_strobe, busy, done;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pio_strobe_gen i_pio_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wbuf_busy(wbuf_busy),
    .req(req), .req_unit(req_unit), .req_write(req_write), .iordy(iordy),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .busy(busy), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  // Runs one cycle; counts strobe clocks and recovery clocks; optional mid-cycle write / req.
  task automatic run_cyc(input int u, input bit w, input int hi_at,
                         input bit mid, input logic [7:0] ma, input logic [7:0] md,
                         input bit xreq, output int act, output int rec,
                         output int bad_strobe, output int post_ok);
    int c;
    act = 0; rec = 0; bad_strobe = 0; post_ok = 0; c = 0;
    @(negedge clk);
    iordy = (hi_at == 0); req = 1'b1; req_unit = 2'(u); req_write = w;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      c++;
      if (c == 1) req = 1'b0;
      if ((w ? rd_strobe : wr_strobe)) bad_strobe++;
      if (w ? wr_strobe : rd_strobe) act++;
      else if (busy) rec++;
      else begin
        if (!done) bad_strobe++;
        break;
      end
      iordy = (hi_at == 0) || (act >= hi_at);
      if (c == 2) begin
        if (mid) begin cfg_wr = 1'b1; cfg_addr = ma; cfg_wdata = md; end
        if (xreq) begin req = 1'b1; req_unit = 2'(u ^ 1); req_write = !w; end
      end
      if (c == 3) begin cfg_wr = 1'b0; req = 1'b0; end
    end
    iordy = 1'b1;
    @(negedge clk);
    post_ok = (!done && !busy && !rd_strobe && !wr_strobe);
  endtask

  localparam int NV = 6;
  localparam int V_UNIT [NV] = '{0, 1, 2, 3, 2, 1};
  localparam bit V_WR   [NV] = '{0, 1, 0, 1, 1, 0};
  localparam logic [7:0] V_BYTE [NV] = '{8'hF0, 8'h0F, 8'h5A, 8'hA3, 8'h77, 8'hFF};
  localparam int V_ACT  [NV] = '{17, 2, 7, 14, 10, 2};
  localparam int V_REC  [NV] = '{1, 16, 11, 6, 9, 1};

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int a, r, b, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 strobes", rd_strobe | wr_strobe, 0);
    cfg_read(8'h42, rd); chk("R1 ctrl", rd, 8'hF0);
    cfg_read(8'h4B, rd); chk("R1 timing", rd, 8'h00);
    run_cyc(0, 0, 0, 0, 0, 0, 0, a, r, b, p);
    chk("R1 default act", a, 17); chk("R1 default rec", r, 16);
    chk("R4 done single", p, 1);

    for (int i = 0; i < NV; i++) begin
      cfg_write(8'(8'h44 + 2*V_UNIT[i] + int'(V_WR[i])), V_BYTE[i]);
      cfg_write(8'(8'h44 + 2*V_UNIT[i] + int'(!V_WR[i])), ~V_BYTE[i]);
      run_cyc(V_UNIT[i], V_WR[i], 0, 0, 0, 0, 0, a, r, b, p);
      chk("R3 act", a, V_ACT[i]); chk("R4 rec", r, V_REC[i]);
      chk("R5 other strobe", b, 0); chk("R4 done pulse", p, 1);
    end

    // R2 decode
    cfg_write(8'h49, 8'h3C);
    cfg_read(8'h49, rd); chk("R2 readback", rd, 8'h3C);
    cfg_read(8'h48, rd); chk("R2 other byte", rd, 8'h88);
    cfg_write(8'h42, 8'hFF);
    cfg_read(8'h42, rd); chk("R2 ctrl low bits", rd, 8'hF0);
    cfg_read(8'h4C, rd); chk("R2 unmapped", rd, 8'h00);
    @(negedge clk); wbuf_busy = 2'b10;
    cfg_read(8'h43, rd); chk("R2 status", rd, 8'h02);

    // R7 writes refused while buffers busy
    cfg_write(8'h44, 8'h00);
    cfg_write(8'h42, 8'h00);
    cfg_read(8'h44, rd); chk("R7 timing kept", rd, 8'hF0);
    cfg_read(8'h42, rd); chk("R7 ctrl kept", rd, 8'hF0);
    @(negedge clk); wbuf_busy = 2'b00;
    run_cyc(0, 0, 0, 0, 0, 0, 0, a, r, b, p);
    chk("R7 act unchanged", a, 17); chk("R7 rec unchanged", r, 1);

    // R6 ready stretching: unit1 honours, unit0 ignores
    cfg_write(8'h42, 8'hD0);
    cfg_write(8'h46, 8'hEE);
    run_cyc(1, 0, 6, 0, 0, 0, 0, a, r, b, p);
    chk("R6 stretched", a, 6); chk("R6 rec after stretch", r, 2);
    run_cyc(1, 0, 3, 0, 0, 0, 0, a, r, b, p);
    chk("R6 ready at last clock", a, 3);
    run_cyc(1, 0, 0, 0, 0, 0, 0, a, r, b, p);
    chk("R6 ready high", a, 3);
    cfg_write(8'h44, 8'hEC);
    run_cyc(0, 0, 8, 0, 0, 0, 0, a, r, b, p);
    chk("R6 ignored", a, 5);

    // R8 snapshot at request
    cfg_write(8'h48, 8'h11);
    run_cyc(2, 0, 0, 1, 8'h48, 8'h22, 0, a, r, b, p);
    chk("R8 old act", a, 16); chk("R8 old rec", r, 15);
    run_cyc(2, 0, 0, 0, 0, 0, 0, a, r, b, p);
    chk("R8 new act", a, 15); chk("R8 new rec", r, 14);

    // R9 request while busy ignored
    run_cyc(2, 0, 0, 0, 0, 0, 1, a, r, b, p);
    chk("R9 act", a, 15); chk("R9 other strobe", b, 0);
    chk("R9 no extra cycle", p, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule